// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block keeps a small set of recent page mappings from virtual to physical addresses. A lookup presents a 32-bit virtual address. The upper 20 bits, the page number, are compared against every stored entry in the same cycle. The lower 12 bits, the offset within the page, bypass the storage entirely. One cycle later the block answers with one of two results. On a hit it returns the physical address, made of the stored frame number followed by the untouched offset, together with that entry's control bits. On a miss it raises a request to the page-table walker and repeats the page number that missed.

The walker answers a miss with a refill. A refill writes one entry. If the page number is already stored, that entry is rewritten. Otherwise the block takes the lowest-numbered empty entry. When every entry holds a mapping, the block overwrites the one used least recently. A flush input empties the whole buffer in one cycle.

Store accesses are checked against two control bits. A store to a page that is not writable, or to a page whose modified flag is still clear, is answered as a miss. The walker can then raise a fault or set the flag.

Top module: `tlb_fa`

## Requirements
- R1: After reset no entry is valid. `respValid`, `respHit` and `missReq` are 0, and a first lookup misses.
- R2: A lookup accepted at a clock edge is answered at the next edge with `respValid`=1. A read lookup whose page number (address bits 31:12) matches a valid entry gives `respHit`=1, `respPaddr` = {stored frame, address bits 11:0}, and `respCtrl` = the stored control bits.
- R3: A lookup that does not hit gives `respHit`=0, `missReq`=1 and `missVpn` = the page number that missed. In that response `respPaddr` and `respCtrl` are 0.
- R4: Control bit 0 means writable and control bit 1 means modified. A store lookup (`lookupWrite`=1) hits only if both bits are 1; otherwise it is answered as a miss. Read lookups ignore both bits.
- R5: A refill whose page number is already held in a valid entry rewrites that entry's frame and control bits. No second copy is made.
- R6: A refill of a new page number goes to the lowest-numbered invalid entry while any entry is invalid, so no valid mapping is lost.
- R7: With all entries valid, a refill of a new page number replaces the least-recently-used entry. Both a hit and a refill count as a use.
- R8: A lookup that misses, including a store that is refused, does not change the recency order.
- R9: A flush invalidates every entry in one cycle. Every lookup after it misses until the page is refilled.
- R10: Priority is flush over refill over lookup. A lookup in the same cycle as a refill or a flush gets no response (`respValid`=0). A refill in the same cycle as a flush is dropped.
- R11: The offset bits of `respPaddr` on a hit equal bits 11:0 of the looked-up address, for every offset value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flushAll | input | 1 | Invalidate every entry |
| lookupValid | input | 1 | Lookup request |
| lookupWrite | input | 1 | Lookup is a store access |
| lookupVaddr | input | 32 | Virtual address to translate |
| refillValid | input | 1 | Write a mapping from the walker |
| refillVpn | input | 20 | Page number of the refill |
| refillPfn | input | 20 | Frame number of the refill |
| refillCtrl | input | 3 | Control bits of the refill (bit0 writable, bit1 modified, bit2 executable) |
| respValid | output | 1 | Lookup answer present |
| respHit | output | 1 | Lookup hit with permission |
| respPaddr | output | 32 | Translated physical address on a hit |
| respCtrl | output | 3 | Control bits of the entry that hit |
| missReq | output | 1 | Request to the walker |
| missVpn | output | 20 | Page number that missed |

## Verification
Most faults inside the block do not show at once. They show on a later lookup. If a valid bit is wrong, a stale or flushed page answers as a hit, or a fresh page misses, on the first lookup of that page. If the recency order is corrupted, nothing is visible until the buffer is full and a refill replaces the wrong entry. The error then shows as a hit or a miss on the next lookup of either page. For this reason the bench keeps its own model of the mappings and of the last-use times. It checks every response one cycle after each request, across directed sweeps and a long run of mixed random traffic over a page pool larger than the buffer.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  localparam int CTRL_WRITE_BIT = 0;
  localparam int CTRL_DIRTY_BIT = 1;

  typedef struct packed {
    logic doFlush;
    logic doRefill;
    logic doLookup;
    logic grant;
  } tlbStrobe_t;

endpackage

// File: rtl/tlb_age.sv
module tlb_age #(
  parameter int ENTRIES = 16,
  localparam int AGE_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] useSel,
  output logic [ENTRIES-1:0] oldestVec
);

  logic [ENTRIES-1:0][AGE_W-1:0] age;
  logic [AGE_W-1:0]              selAge;
  logic                          anyUse;

  assign anyUse = |useSel;

  always_comb begin
    selAge = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (useSel[i]) selAge = selAge | age[i];
    end
  end

  // Ages form a permutation: the used entry becomes 0, younger ones shift up.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) age[i] <= AGE_W'(i);
    end else if (anyUse) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (useSel[i])            age[i] <= '0;
        else if (age[i] < selAge) age[i] <= age[i] + 1'b1;
      end
    end
  end

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_oldest
      assign oldestVec[g] = (age[g] == AGE_W'(ENTRIES - 1));
    end
  endgenerate

endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int CTRL_W  = 3
) (
  input  logic               flushAll,
  input  logic               refillValid,
  input  logic               lookupValid,
  input  logic               lookupWrite,
  input  logic [ENTRIES-1:0] lookupMatch,
  input  logic [ENTRIES-1:0] refillMatch,
  input  logic [ENTRIES-1:0] validVec,
  input  logic [ENTRIES-1:0] oldestVec,
  input  logic [CTRL_W-1:0]  hitCtrl,
  output tlbStrobe_t         strobe,
  output logic [ENTRIES-1:0] refillSel,
  output logic [ENTRIES-1:0] useSel
);

  logic [ENTRIES-1:0] invalidVec;
  logic [ENTRIES-1:0] firstInvalid;
  logic               anyMatch;
  logic               permitOk;

  assign invalidVec   = ~validVec;
  assign firstInvalid = invalidVec & (~invalidVec + ENTRIES'(1));

  always_comb begin
    if (|refillMatch)     refillSel = refillMatch;
    else if (|invalidVec) refillSel = firstInvalid;
    else                  refillSel = oldestVec;
  end

  assign anyMatch = |lookupMatch;
  assign permitOk = !lookupWrite ||
                    (hitCtrl[CTRL_WRITE_BIT] && hitCtrl[CTRL_DIRTY_BIT]);

  always_comb begin
    strobe.doFlush  = flushAll;
    strobe.doRefill = refillValid && !flushAll;
    strobe.doLookup = lookupValid && !refillValid && !flushAll;
    strobe.grant    = strobe.doLookup && anyMatch && permitOk;
  end

  always_comb begin
    if (strobe.doRefill)   useSel = refillSel;
    else if (strobe.grant) useSel = lookupMatch;
    else                   useSel = '0;
  end

endmodule

// File: rtl/tlb_dp.sv
module tlb_dp
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int OFF_W   = 12,
  parameter int CTRL_W  = 3,
  localparam int PA_W   = PFN_W + OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  tlbStrobe_t         strobe,
  input  logic [ENTRIES-1:0] refillSel,
  input  logic [VPN_W-1:0]   lookupVpn,
  input  logic [OFF_W-1:0]   lookupOff,
  input  logic [VPN_W-1:0]   refillVpn,
  input  logic [PFN_W-1:0]   refillPfn,
  input  logic [CTRL_W-1:0]  refillCtrl,
  output logic [ENTRIES-1:0] lookupMatch,
  output logic [ENTRIES-1:0] refillMatch,
  output logic [ENTRIES-1:0] validVec,
  output logic [CTRL_W-1:0]  hitCtrl,
  output logic               respValid,
  output logic               respHit,
  output logic [PA_W-1:0]    respPaddr,
  output logic [CTRL_W-1:0]  respCtrl,
  output logic               missReq,
  output logic [VPN_W-1:0]   missVpn
);

  logic [ENTRIES-1:0][VPN_W-1:0]  vpnMem;
  logic [ENTRIES-1:0][PFN_W-1:0]  pfnMem;
  logic [ENTRIES-1:0][CTRL_W-1:0] ctrlMem;
  logic [PFN_W-1:0]               hitPfn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               validVec <= '0;
    else if (strobe.doFlush)  validVec <= '0;
    else if (strobe.doRefill) validVec <= validVec | refillSel;
  end

  always_ff @(posedge clk) begin
    if (strobe.doRefill) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (refillSel[i]) begin
          vpnMem[i]  <= refillVpn;
          pfnMem[i]  <= refillPfn;
          ctrlMem[i] <= refillCtrl;
        end
      end
    end
  end

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign lookupMatch[g] = validVec[g] && (vpnMem[g] == lookupVpn);
      assign refillMatch[g] = validVec[g] && (vpnMem[g] == refillVpn);
    end
  endgenerate

  always_comb begin
    hitPfn  = '0;
    hitCtrl = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lookupMatch[i]) begin
        hitPfn  = hitPfn | pfnMem[i];
        hitCtrl = hitCtrl | ctrlMem[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      respValid <= 1'b0;
      respHit   <= 1'b0;
      respPaddr <= '0;
      respCtrl  <= '0;
      missReq   <= 1'b0;
      missVpn   <= '0;
    end else begin
      respValid <= strobe.doLookup;
      respHit   <= strobe.grant;
      missReq   <= strobe.doLookup && !strobe.grant;
      respPaddr <= strobe.grant ? {hitPfn, lookupOff} : '0;
      respCtrl  <= strobe.grant ? hitCtrl : '0;
      if (strobe.doLookup) missVpn <= lookupVpn;
    end
  end

endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int OFF_W   = 12,
  parameter int CTRL_W  = 3,
  localparam int VA_W   = VPN_W + OFF_W,
  localparam int PA_W   = PFN_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flushAll,
  input  logic              lookupValid,
  input  logic              lookupWrite,
  input  logic [VA_W-1:0]   lookupVaddr,
  input  logic              refillValid,
  input  logic [VPN_W-1:0]  refillVpn,
  input  logic [PFN_W-1:0]  refillPfn,
  input  logic [CTRL_W-1:0] refillCtrl,
  output logic              respValid,
  output logic              respHit,
  output logic [PA_W-1:0]   respPaddr,
  output logic [CTRL_W-1:0] respCtrl,
  output logic              missReq,
  output logic [VPN_W-1:0]  missVpn
);

  tlbStrobe_t         strobe;
  logic [ENTRIES-1:0] lookupMatch;
  logic [ENTRIES-1:0] refillMatch;
  logic [ENTRIES-1:0] validVec;
  logic [ENTRIES-1:0] oldestVec;
  logic [ENTRIES-1:0] refillSel;
  logic [ENTRIES-1:0] useSel;
  logic [CTRL_W-1:0]  hitCtrl;

  tlb_ctrl #(.ENTRIES(ENTRIES), .CTRL_W(CTRL_W)) u_ctrl (
    .flushAll    (flushAll),
    .refillValid (refillValid),
    .lookupValid (lookupValid),
    .lookupWrite (lookupWrite),
    .lookupMatch (lookupMatch),
    .refillMatch (refillMatch),
    .validVec    (validVec),
    .oldestVec   (oldestVec),
    .hitCtrl     (hitCtrl),
    .strobe      (strobe),
    .refillSel   (refillSel),
    .useSel      (useSel)
  );

  tlb_dp #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W),
    .OFF_W(OFF_W), .CTRL_W(CTRL_W)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .refillSel   (refillSel),
    .lookupVpn   (lookupVaddr[VA_W-1:OFF_W]),
    .lookupOff   (lookupVaddr[OFF_W-1:0]),
    .refillVpn   (refillVpn),
    .refillPfn   (refillPfn),
    .refillCtrl  (refillCtrl),
    .lookupMatch (lookupMatch),
    .refillMatch (refillMatch),
    .validVec    (validVec),
    .hitCtrl     (hitCtrl),
    .respValid   (respValid),
    .respHit     (respHit),
    .respPaddr   (respPaddr),
    .respCtrl    (respCtrl),
    .missReq     (missReq),
    .missVpn     (missVpn)
  );

  tlb_age #(.ENTRIES(ENTRIES)) u_age (
    .clk       (clk),
    .rst_n     (rst_n),
    .useSel    (useSel),
    .oldestVec (oldestVec)
  );

endmodule

// File: rtl/tlb_fa_chk.sv
module tlb_fa_chk #(
  parameter int VPN_W  = 20,
  parameter int PFN_W  = 20,
  parameter int OFF_W  = 12,
  parameter int CTRL_W = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     flushAll,
  input logic                     lookupValid,
  input logic                     lookupWrite,
  input logic [VPN_W+OFF_W-1:0]   lookupVaddr,
  input logic                     refillValid,
  input logic [VPN_W-1:0]         refillVpn,
  input logic [PFN_W-1:0]         refillPfn,
  input logic [CTRL_W-1:0]        refillCtrl,
  input logic                     respValid,
  input logic                     respHit,
  input logic [PFN_W+OFF_W-1:0]   respPaddr,
  input logic [CTRL_W-1:0]        respCtrl,
  input logic                     missReq,
  input logic [VPN_W-1:0]         missVpn
);

  assert_answer_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lookupValid && !refillValid && !flushAll) |=> respValid);

  assert_hit_in_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    respHit |-> respValid);

  assert_miss_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    missReq |-> (respValid && !respHit));

  assert_miss_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    missReq |-> (respPaddr == '0 && respCtrl == '0));

  assert_store_perm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (respHit && $past(lookupWrite)) |-> (respCtrl[0] && respCtrl[1]));

  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flushAll ##1 (lookupValid && !refillValid && !flushAll) |=> !respHit);

  assert_no_answer_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flushAll || refillValid) |=> !respValid);

  assert_offset_pass_R11: assert property (@(posedge clk) disable iff (!rst_n)
    respHit |-> (respPaddr[OFF_W-1:0] == $past(lookupVaddr[OFF_W-1:0])));

endmodule

bind tlb_fa tlb_fa_chk #(
  .VPN_W(VPN_W), .PFN_W(PFN_W), .OFF_W(OFF_W), .CTRL_W(CTRL_W)
) u_chk (.*);

// File: tb/tlb_fa_tb.sv
module tlb_fa_tb;

  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        flushAll, lookupValid, lookupWrite, refillValid;
  logic [31:0] lookupVaddr;
  logic [19:0] refillVpn, refillPfn;
  logic [2:0]  refillCtrl;
  logic        respValid, respHit, missReq;
  logic [31:0] respPaddr;
  logic [2:0]  respCtrl;
  logic [19:0] missVpn;

  int checks = 0;
  int failures = 0;

  bit        mValid [N];
  logic [19:0] mVpn [N];
  logic [19:0] mPfn [N];
  logic [2:0]  mCtrl [N];
  int        mUse [N];
  int        useClock = 0;

  always #2 clk = ~clk;

  tlb_fa u_dut (
    .clk(clk), .rst_n(rst_n), .flushAll(flushAll), .lookupValid(lookupValid),
    .lookupWrite(lookupWrite), .lookupVaddr(lookupVaddr), .refillValid(refillValid),
    .refillVpn(refillVpn), .refillPfn(refillPfn), .refillCtrl(refillCtrl),
    .respValid(respValid), .respHit(respHit), .respPaddr(respPaddr),
    .respCtrl(respCtrl), .missReq(missReq), .missVpn(missVpn)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int findVpn(input logic [19:0] v);
    for (int i = 0; i < N; i++) if (mValid[i] && mVpn[i] == v) return i;
    return -1;
  endfunction

  task automatic modelRefill(input logic [19:0] v, input logic [19:0] p, input logic [2:0] c);
    int idx = findVpn(v);
    if (idx < 0) for (int i = N - 1; i >= 0; i--) if (!mValid[i]) idx = i;
    if (idx < 0) begin
      idx = 0;
      for (int i = 1; i < N; i++) if (mUse[i] < mUse[idx]) idx = i;
    end
    mValid[idx] = 1'b1;
    mVpn[idx] = v;
    mPfn[idx] = p;
    mCtrl[idx] = c;
    useClock++;
    mUse[idx] = useClock;
  endtask

  // Called at a falling edge; drives one cycle of stimulus and checks the answer.
  task automatic op(input bit lv, input bit wr, input logic [31:0] va,
                    input bit rv, input logic [19:0] rvpn, input logic [19:0] rpfn,
                    input logic [2:0] rc, input bit fl, input string tag);
    bit eLook, eGrant;
    int idx;
    logic [31:0] ePa;
    logic [2:0] eCtrl;
    lookupValid = lv; lookupWrite = wr; lookupVaddr = va;
    refillValid = rv; refillVpn = rvpn; refillPfn = rpfn; refillCtrl = rc;
    flushAll = fl;
    eLook = lv && !rv && !fl;
    idx = findVpn(va[31:12]);
    eGrant = eLook && idx >= 0 && (!wr || (mCtrl[idx][0] && mCtrl[idx][1]));
    ePa = eGrant ? {mPfn[idx], va[11:0]} : 32'h0;
    eCtrl = eGrant ? mCtrl[idx] : 3'b0;
    @(negedge clk);
    chk({respValid, respHit, missReq} == {eLook, eGrant, eLook && !eGrant}, tag,
        "valid/hit/miss", {61'b0, respValid, respHit, missReq},
        {61'b0, eLook, eGrant, eLook && !eGrant});
    if (eLook) begin
      chk(respPaddr == ePa, tag, "paddr", 64'(respPaddr), 64'(ePa));
      chk(respCtrl == eCtrl, tag, "ctrl", 64'(respCtrl), 64'(eCtrl));
      if (!eGrant) chk(missVpn == va[31:12], tag, "missVpn", 64'(missVpn), 64'(va[31:12]));
    end
    if (fl) begin
      for (int i = 0; i < N; i++) mValid[i] = 1'b0;
    end else if (rv) begin
      modelRefill(rvpn, rpfn, rc);
    end else if (eGrant) begin
      useClock++;
      mUse[idx] = useClock;
    end
  endtask

  task automatic look(input logic [19:0] v, input logic [11:0] off, input bit wr, input string tag);
    op(1'b1, wr, {v, off}, 1'b0, 20'h0, 20'h0, 3'b0, 1'b0, tag);
  endtask

  task automatic fill(input logic [19:0] v, input logic [19:0] p, input logic [2:0] c, input string tag);
    op(1'b0, 1'b0, 32'h0, 1'b1, v, p, c, 1'b0, tag);
  endtask

  task automatic idle();
    op(1'b0, 1'b0, 32'h0, 1'b0, 20'h0, 20'h0, 3'b0, 1'b0, "R2");
  endtask

  function automatic logic [19:0] poolVpn(input int k);
    return 20'(32'h1000 + k * 3);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    flushAll = 0; lookupValid = 0; lookupWrite = 0; refillValid = 0;
    lookupVaddr = '0; refillVpn = '0; refillPfn = '0; refillCtrl = '0;
    for (int i = 0; i < N; i++) begin mValid[i] = 0; mUse[i] = 0; end
    repeat (3) @(negedge clk);
    chk({respValid, respHit, missReq} == 3'b000, "R1", "reset outputs",
        64'({respValid, respHit, missReq}), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    look(20'h00005, 12'h123, 1'b0, "R1");

    // R6: fill every entry from empty
    for (int i = 0; i < N; i++)
      fill(poolVpn(i), 20'hA0000 ^ 20'(i * 257), 3'(i), "R6");
    // R2 / R11: read hits with several offsets
    for (int i = 0; i < N; i++) begin
      look(poolVpn(i), 12'h000, 1'b0, "R2");
      look(poolVpn(i), 12'hFFF, 1'b0, "R11");
      look(poolVpn(i), 12'(i * 73 + 5), 1'b0, "R11");
    end
    // R4: store permission for every control pattern
    for (int i = 0; i < N; i++) look(poolVpn(i), 12'h040, 1'b1, "R4");
    // R3: misses
    for (int i = 0; i < 8; i++) look(20'h80000 + 20'(i), 12'(i), 1'b0, "R3");

    // R7 / R8: touch some entries, refuse a store, then evict
    for (int i = 0; i < 6; i++) look(poolVpn(2 * i), 12'h0, 1'b0, "R7");
    look(poolVpn(1), 12'h0, 1'b1, "R8");
    look(20'h90000, 12'h0, 1'b0, "R8");
    for (int i = 0; i < 4; i++) fill(poolVpn(40 + i), 20'h55500 + 20'(i), 3'b011, "R7");
    for (int i = 0; i < N; i++) look(poolVpn(i), 12'h1, 1'b0, "R7");
    for (int i = 0; i < 4; i++) look(poolVpn(40 + i), 12'h2, 1'b0, "R7");

    // R5: rewrite an existing mapping
    fill(poolVpn(40), 20'h12345, 3'b111, "R5");
    look(poolVpn(40), 12'hABC, 1'b1, "R5");
    for (int i = 0; i < 4; i++) look(poolVpn(40 + i), 12'h3, 1'b0, "R5");

    // R10: priority
    op(1'b1, 1'b0, {poolVpn(41), 12'h0}, 1'b1, 20'h77777, 20'h00001, 3'b001, 1'b0, "R10");
    look(20'h77777, 12'h010, 1'b0, "R10");
    op(1'b0, 1'b0, 32'h0, 1'b1, 20'h66666, 20'h00002, 3'b011, 1'b1, "R10");
    look(20'h66666, 12'h0, 1'b0, "R10");
    look(20'h77777, 12'h0, 1'b0, "R9");

    // R9 / R6: flush, confirm empty, refill all, confirm nothing lost
    for (int i = 0; i < N; i++) fill(poolVpn(60 + i), 20'(i + 1), 3'b010, "R6");
    op(1'b1, 1'b0, {poolVpn(60), 12'h0}, 1'b0, 20'h0, 20'h0, 3'b0, 1'b1, "R10");
    for (int i = 0; i < N; i++) look(poolVpn(60 + i), 12'h7, 1'b0, "R9");
    for (int i = 0; i < N; i++) fill(poolVpn(80 + i), 20'(i + 100), 3'b111, "R6");
    for (int i = 0; i < N; i++) look(poolVpn(80 + i), 12'h8, 1'b1, "R6");

    // R7: mixed random traffic over a pool larger than the buffer
    for (int n = 0; n < 4000; n++) begin
      int kind = $urandom_range(0, 99);
      logic [19:0] v = poolVpn($urandom_range(0, 23));
      logic [11:0] off = 12'($urandom);
      if (kind < 55)
        look(v, off, 1'($urandom_range(0, 1)), "R7");
      else if (kind < 85)
        fill(v, 20'($urandom), 3'($urandom), "R7");
      else if (kind < 88)
        op(1'b1, 1'b0, {v, off}, 1'b0, 20'h0, 20'h0, 3'b0, 1'b1, "R9");
      else if (kind < 93)
        op(1'b1, 1'b0, {v, off}, 1'b1, poolVpn($urandom_range(0, 23)),
           20'($urandom), 3'($urandom), 1'b0, "R10");
      else
        idle();
    end
    idle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule